// File: doc/BRIEF.md
# Instruction Fetch Address Sequencer

This block holds the program counter of a small processor core. Each cycle it produces a 13-bit fetch address for an instruction store of up to 8K words of 14 bits. Four one-hot control strobes tell it what to do: take an interrupt, return, call or jump. When none of them is active, the counter steps to the next word. Jump and call targets carry only the low 11 address bits. The two upper bits come from a separate page-select input, so the program space works as four 2K-word pages.

An internal circular stack of eight return addresses serves calls, interrupt entries and all three kinds of return. No memory access is involved. The parameter `MEM_WORDS` sets the implemented store size as a power of two. Every address the block produces is folded into that size, so a 4K-word variant wraps any higher address back into its space.

The interface carries only plain control strobes and an address. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure. The consumer must accept a new fetch address on every clock.

Top module: `pc_seq`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0 at once and every stack slot is cleared to 0. Reset overrides every strobe.
- R2: In a cycle with no strobe active, `fetch_addr` becomes `(fetch_addr + 1) mod MEM_WORDS` at the next clock edge.
- R3: A jump loads `{page_sel, target}` reduced mod `MEM_WORDS`, with `target` in bits 10:0 and `page_sel` in bits 12:11. A jump does not touch the stack.
- R4: A call loads the same address as a jump. It also pushes `(fetch_addr + 1) mod MEM_WORDS`. A return loads the most recently pushed entry and pops it.
- R5: An interrupt loads 4 (0004h) and pushes `(fetch_addr + 1) mod MEM_WORDS`. A later return resumes at that address.
- R6: When strobes overlap, priority runs from highest to lowest as reset, interrupt, return, call, jump. Only the winner acts: there is one stack operation at most per cycle.
- R7: The stack is circular with 8 slots. A ninth push overwrites the oldest entry. A pop on an empty stack returns the slot that the pointer wraps to, and no flag is raised in either case.
- R8: With `MEM_WORDS` = 4096, stepping from 0FFFh gives 0000h. A jump to page 2 lands in page 0 and a jump to page 3 lands in page 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_take | input | 1 | Enter the interrupt vector this cycle |
| ret_take | input | 1 | Return to the address on top of the stack |
| call_take | input | 1 | Call: jump and push the return address |
| jump_take | input | 1 | Jump within the page chosen by page_sel |
| target | input | 11 | In-page target address for jump and call |
| page_sel | input | 2 | Upper address bits for jump and call |
| fetch_addr | output | 13 | Current instruction fetch address |

## Verification
The assertions assume that the strobes and the target are stable and free of X across each clock edge. They also assume that overlapping strobes are legal, so the priority properties exclude the higher strobes explicitly. The bench drives every input at the falling edge only, and it deliberately overlaps strobes to exercise the priority order. Its stack overflow and empty-pop sequences stay within what the circular stack defines, so the stack pointer never moves with an undefined value.

// File: rtl/pcq_pkg.sv
package pcq_pkg;
  typedef enum logic [2:0] {
    SRC_STEP,
    SRC_IRQ,
    SRC_RET,
    SRC_CALL,
    SRC_JUMP
  } pc_src_e;
endpackage

// File: rtl/pc_src_arb.sv
module pc_src_arb
  import pcq_pkg::*;
(
  input  logic    irq_take,
  input  logic    ret_take,
  input  logic    call_take,
  input  logic    jump_take,
  output pc_src_e src,
  output logic    push,
  output logic    pop
);
  always_comb begin
    if (irq_take)       src = SRC_IRQ;
    else if (ret_take)  src = SRC_RET;
    else if (call_take) src = SRC_CALL;
    else if (jump_take) src = SRC_JUMP;
    else                src = SRC_STEP;
    push = (src == SRC_IRQ) || (src == SRC_CALL);
    pop  = (src == SRC_RET);
  end
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_dec;

  assign ptr_dec  = ptr_q - PTR_W'(1);
  assign top_data = slot_q[ptr_dec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (push) begin
      slot_q[ptr_q] <= push_data;
      ptr_q         <= ptr_q + PTR_W'(1);
    end else if (pop) begin
      ptr_q <= ptr_dec;
    end
  end

  AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R6
  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> ptr_q == $past(ptr_q) + PTR_W'(1)); // R7
  AST_POP_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> ptr_q == $past(ptr_q) - PTR_W'(1)); // R7
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pcq_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int TGT_W       = 11,
  parameter int MEM_WORDS   = 8192,
  parameter int STACK_DEPTH = 8,
  parameter int IRQ_VECTOR  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     irq_take,
  input  logic                     ret_take,
  input  logic                     call_take,
  input  logic                     jump_take,
  input  logic [TGT_W-1:0]         target,
  input  logic [ADDR_W-TGT_W-1:0]  page_sel,
  output logic [ADDR_W-1:0]        fetch_addr
);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(MEM_WORDS - 1);
  localparam logic [ADDR_W-1:0] IRQ_ADDR  = ADDR_W'(IRQ_VECTOR);

  pc_src_e           src;
  logic              push, pop;
  logic [ADDR_W-1:0] pc_q, pc_d, seq_addr, far_addr, top_data;

  pc_src_arb u_arb (
    .irq_take (irq_take),
    .ret_take (ret_take),
    .call_take(call_take),
    .jump_take(jump_take),
    .src      (src),
    .push     (push),
    .pop      (pop)
  );

  pc_ret_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .push_data(seq_addr),
    .top_data (top_data)
  );

  assign seq_addr = (pc_q + ADDR_W'(1)) & ADDR_MASK;
  assign far_addr = {page_sel, target} & ADDR_MASK;

  always_comb begin
    unique case (src)
      SRC_IRQ:           pc_d = IRQ_ADDR;
      SRC_RET:           pc_d = top_data & ADDR_MASK;
      SRC_CALL, SRC_JUMP: pc_d = far_addr;
      default:           pc_d = seq_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> fetch_addr == '0); // R1
  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_take || ret_take || call_take || jump_take)
      |=> fetch_addr == (($past(fetch_addr) + ADDR_W'(1)) & ADDR_MASK)); // R2
  AST_JUMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_take && !irq_take && !ret_take && !call_take)
      |=> fetch_addr[TGT_W-1:0] == $past(target)); // R3
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> fetch_addr == IRQ_ADDR); // R5
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr & ~ADDR_MASK) == '0); // R8
endmodule

// File: tb/sim_pc_seq.sv
`timescale 1ns/1ps
module sim_pc_seq;
  localparam int MW = 4096;
  localparam logic [12:0] MSK = 13'(MW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_take = 0, ret_take = 0, call_take = 0, jump_take = 0;
  logic [10:0] target = '0;
  logic [1:0]  page_sel = '0;
  logic [12:0] fetch_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [12:0] exp_q[$];
  string       tag_q[$];

  logic [12:0] m_pc;
  logic [12:0] m_stk [8];
  logic [2:0]  m_ptr;

  always #2.5 clk = ~clk;

  pc_seq #(.MEM_WORDS(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .ret_take(ret_take),
    .call_take(call_take), .jump_take(jump_take), .target(target),
    .page_sel(page_sel), .fetch_addr(fetch_addr)
  );

  task automatic model_reset();
    m_pc = '0;
    m_ptr = '0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
  endtask

  // drive one cycle at the falling edge and queue the expected address
  task automatic drv(input bit irq, input bit ret, input bit call, input bit jmp,
                     input logic [10:0] tg, input logic [1:0] pg, input string tag);
    logic [12:0] nxt;
    irq_take = irq; ret_take = ret; call_take = call; jump_take = jmp;
    target = tg; page_sel = pg;
    nxt = (m_pc + 13'd1) & MSK;
    if (irq) begin
      m_stk[m_ptr] = nxt; m_ptr = m_ptr + 3'd1; m_pc = 13'd4;
    end else if (ret) begin
      m_ptr = m_ptr - 3'd1; m_pc = m_stk[m_ptr] & MSK;
    end else if (call) begin
      m_stk[m_ptr] = nxt; m_ptr = m_ptr + 3'd1; m_pc = {pg, tg} & MSK;
    end else if (jmp) begin
      m_pc = {pg, tg} & MSK;
    end else begin
      m_pc = nxt;
    end
    exp_q.push_back(m_pc);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic step(input string tag);
    drv(0, 0, 0, 0, '0, '0, tag);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [12:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (fetch_addr !== e) begin
        errors++;
        $display("FAIL %s: fetch_addr=%h expected=%h", t, fetch_addr, e);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (fetch_addr !== 13'h0) begin
      errors++; $display("FAIL R1 reset: fetch_addr=%h expected=0000", fetch_addr);
    end
    rst_n = 1'b1;
    step("R2 step"); step("R2 step"); step("R2 step");
    drv(0, 0, 0, 1, 11'h123, 2'd1, "R3 jump page1");
    step("R2 step after jump");
    drv(0, 0, 1, 0, 11'h050, 2'd0, "R4 call");
    step("R2 step in callee");
    drv(0, 1, 0, 0, '0, '0, "R4 return");
    drv(1, 0, 0, 0, '0, '0, "R5 irq vector");
    step("R5 step after vector");
    drv(0, 1, 0, 0, '0, '0, "R5 return from irq");
    drv(1, 1, 1, 1, 11'h3, 2'd1, "R6 irq wins all");
    drv(0, 1, 1, 1, 11'h3, 2'd1, "R6 return beats call");
    drv(0, 0, 1, 1, 11'h200, 2'd0, "R6 call beats jump");
    drv(0, 1, 0, 0, '0, '0, "R6 return after call");
    drv(0, 0, 0, 1, 11'h7FF, 2'd1, "R8 jump to top");
    step("R8 wrap to zero");
    drv(0, 0, 0, 1, 11'h010, 2'd3, "R8 page3 folds to page1");
    drv(0, 0, 0, 1, 11'h010, 2'd2, "R8 page2 folds to page0");
    for (int i = 0; i < 9; i++) drv(0, 0, 1, 0, 11'(i * 16 + 1), 2'(i % 2), "R7 call fill");
    for (int i = 0; i < 9; i++) drv(0, 1, 0, 0, '0, '0, "R7 return drain");
    drv(0, 1, 0, 0, '0, '0, "R7 pop past empty");
    drv(0, 0, 0, 1, 11'h055, 2'd1, "R3 jump before reset");
    irq_take = 1'b1; rst_n = 1'b0;
    model_reset();
    #0.5;
    checks++;
    if (fetch_addr !== 13'h0) begin
      errors++; $display("FAIL R1 reset over irq: fetch_addr=%h expected=0000", fetch_addr);
    end
    @(negedge clk);
    irq_take = 1'b0; rst_n = 1'b1;
    drv(0, 1, 0, 0, '0, '0, "R1 stack cleared pop");
    step("R2 step after reset");
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule